// File: doc/BRIEF.md
# Clock Source Lock Qualifier

This block chooses the baseband clock source when a device is brought up. A two-bit mode input asks for one of four policies: try the internal PLL and fall back to the 40 MHz external input if it will not lock, insist on the PLL, or take the 48 MHz or 40 MHz external input directly. For a PLL attempt the block powers the PLL up and keeps the clock stopped. It lets a settling time pass, then samples the raw lock flag once per slot until enough hits are seen or the window closes.

Time is measured from a free-running tick input. A fixed number of ticks make one slot, and the settle time and window length are given in slots. With the default parameters a 1 µs tick gives 50 µs slots, a 0.5 ms settle time and a 10 ms window. The clock is never released during selection. A separate start command releases it once a source is selected. An unset command stops the clock first and only then removes the source select and powers the PLL down.

Top module: `clk_src_qual`

## Requirements
- R1: After reset the clock is stopped (clk_stop_o=1) and every other output is 0, with src_o=0 meaning no source.
- R2: A selection request with mode_i=2 (external 48 MHz) or mode_i=3 (external 40 MHz) takes effect at the next edge with no lock check. It gives ext_en_o=1, ext40_o=mode_i[0], done_o=1, pll_pwr_o=0, clock still stopped, and src_o=2 or 3.
- R3: A request with mode_i=0 (auto) or mode_i=1 (PLL only) starts a trial. During the trial busy_o=1, pll_pwr_o=1, clk_stop_o=1 and ext_en_o=0. Ticks are counted from the cycle after the request. Every SLOT_TICKS ticks complete one slot, and the lock flag is sampled only in the cycle that completes slot n with n >= SETTLE_SLOTS.
- R4: The trial ends at the edge that samples the HITS_NEEDED-th asserted lock flag. The result is done_o=1, src_o=1, the PLL kept powered and the clock stopped, and no more samples are taken.
- R5: In PLL-only mode, if the trial reaches slot WINDOW_SLOTS without enough hits, the result is fail_o=1, done_o=0, pll_pwr_o=0, ext_en_o=0, src_o=0, with the clock stopped.
- R6: In auto mode, the same miss gives ext_en_o=1, ext40_o=1, pll_pwr_o=0, done_o=1, src_o=3, with the clock stopped.
- R7: A final hit that lands on slot WINDOW_SLOTS itself counts as success.
- R8: start_i clears clk_stop_o at the next edge only while done_o=1 and busy_o=0. Otherwise it has no effect.
- R9: stop_i sets clk_stop_o. When stop_i and start_i come in the same cycle, the clock stays stopped.
- R10: unset_i on a running clock first sets clk_stop_o and keeps the select, then clears ext_en_o, ext40_o, pll_pwr_o, done_o and src_o one edge later. On a stopped clock it clears them at the next edge.
- R11: A selection request restarts everything: tick, slot and hit counts are cleared, status is cleared and the clock is stopped. In the same cycle it overrides start_i, stop_i and unset_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Policy: 0 auto, 1 PLL only, 2 external 48 MHz, 3 external 40 MHz |
| sel_req_i | input | 1 | Start a new selection with mode_i |
| start_i | input | 1 | Release the clock |
| stop_i | input | 1 | Stop the clock |
| unset_i | input | 1 | Stop, then drop source select and PLL power |
| pll_lock_i | input | 1 | Raw PLL lock flag |
| tick_i | input | 1 | Free-running timebase tick |
| pll_pwr_o | output | 1 | PLL powered (power-down released) |
| ext_en_o | output | 1 | External clock input selected |
| ext40_o | output | 1 | External input is the 40 MHz one |
| clk_stop_o | output | 1 | Internal clock held stopped |
| busy_o | output | 1 | PLL trial in progress |
| done_o | output | 1 | A source is selected |
| fail_o | output | 1 | PLL-only selection failed |
| src_o | output | 2 | Selected source: 0 none, 1 PLL, 2 ext 48, 3 ext 40 |

## Verification
The command path and the selection path can act in the same cycle. A new request may arrive together with start, stop or unset, and stop may arrive together with start. The bench drives these pairs on one edge and checks that the request wins, with the clock left stopped. Within a trial, the window end and the final lock hit can also fall on the same slot. Directed lock patterns put the last hit exactly on the final slot, or one hit short. Randomised trials with irregular ticks are followed cycle by cycle by a bench model of the slot and hit counts.

// File: rtl/clk_qual_pkg.sv
package clk_qual_pkg;
  typedef enum logic [1:0] {
    MODE_AUTO  = 2'd0,
    MODE_PLL   = 2'd1,
    MODE_EXT48 = 2'd2,
    MODE_EXT40 = 2'd3
  } qual_mode_e;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_PLL   = 2'd1,
    SRC_EXT48 = 2'd2,
    SRC_EXT40 = 2'd3
  } qual_src_e;
endpackage

// File: rtl/slot_timer.sv
module slot_timer #(
  parameter int SLOT_TICKS = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  input  logic tick_i,
  output logic slot_o
);
  localparam int TW = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam logic [TW-1:0] LAST = TW'(SLOT_TICKS - 1);

  logic [TW-1:0] cnt_q;

  assign slot_o = run_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clear_i)          cnt_q <= '0;
    else if (run_i && tick_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/lock_sampler.sv
module lock_sampler #(
  parameter int SETTLE_SLOTS = 10,
  parameter int WINDOW_SLOTS = 200,
  parameter int HITS_NEEDED  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  input  logic slot_i,
  input  logic lock_i,
  output logic pass_o,
  output logic expire_o
);
  localparam int SW = $clog2(WINDOW_SLOTS + 1);
  localparam int HW = $clog2(HITS_NEEDED + 1);
  localparam logic [SW-1:0] SETTLE_C = SW'(SETTLE_SLOTS);
  localparam logic [SW-1:0] WIN_C    = SW'(WINDOW_SLOTS);
  localparam logic [HW-1:0] HITS_C   = HW'(HITS_NEEDED);

  logic [SW-1:0] slot_q, slot_nxt;
  logic [HW-1:0] hits_q, hits_nxt;
  logic          sample, hit;

  always_comb begin
    slot_nxt = slot_q + 1'b1;
    sample   = run_i && slot_i && (slot_nxt >= SETTLE_C);
    hit      = sample && lock_i;
    hits_nxt = hits_q + HW'(hit);
    pass_o   = hit && (hits_nxt == HITS_C);
    expire_o = run_i && slot_i && (slot_nxt == WIN_C) && !pass_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      hits_q <= '0;
    end else if (clear_i) begin
      slot_q <= '0;
      hits_q <= '0;
    end else if (run_i && slot_i) begin
      slot_q <= slot_nxt;
      hits_q <= hits_nxt;
    end
  end

  // no hit may be counted inside the settle time
  p_settle_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q < SETTLE_C) |-> (hits_q == '0));
  p_hits_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hits_q <= HITS_C);
endmodule

// File: rtl/clk_src_qual.sv
module clk_src_qual
  import clk_qual_pkg::*;
#(
  parameter int SLOT_TICKS   = 50,
  parameter int SETTLE_SLOTS = 10,
  parameter int WINDOW_SLOTS = 200,
  parameter int HITS_NEEDED  = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       sel_req_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       unset_i,
  input  logic       pll_lock_i,
  input  logic       tick_i,
  output logic       pll_pwr_o,
  output logic       ext_en_o,
  output logic       ext40_o,
  output logic       clk_stop_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       fail_o,
  output logic [1:0] src_o
);
  logic       slot_w, pass_w, expire_w;
  logic       try_q, pll_pwr_q, ext_en_q, ext40_q, stop_q, done_q, fail_q, pend_q;
  qual_src_e  src_q;
  qual_mode_e mode_q, req_mode;

  assign req_mode = qual_mode_e'(mode_i);

  slot_timer #(.SLOT_TICKS(SLOT_TICKS)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (sel_req_i),
    .run_i   (try_q),
    .tick_i  (tick_i),
    .slot_o  (slot_w)
  );

  lock_sampler #(
    .SETTLE_SLOTS (SETTLE_SLOTS),
    .WINDOW_SLOTS (WINDOW_SLOTS),
    .HITS_NEEDED  (HITS_NEEDED)
  ) u_smp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (sel_req_i),
    .run_i    (try_q),
    .slot_i   (slot_w),
    .lock_i   (pll_lock_i),
    .pass_o   (pass_w),
    .expire_o (expire_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      try_q     <= 1'b0;
      pll_pwr_q <= 1'b0;
      ext_en_q  <= 1'b0;
      ext40_q   <= 1'b0;
      stop_q    <= 1'b1;
      done_q    <= 1'b0;
      fail_q    <= 1'b0;
      pend_q    <= 1'b0;
      src_q     <= SRC_NONE;
      mode_q    <= MODE_AUTO;
    end else if (sel_req_i) begin
      stop_q <= 1'b1;
      fail_q <= 1'b0;
      pend_q <= 1'b0;
      mode_q <= req_mode;
      case (req_mode)
        MODE_EXT48, MODE_EXT40: begin
          try_q     <= 1'b0;
          pll_pwr_q <= 1'b0;
          ext_en_q  <= 1'b1;
          ext40_q   <= (req_mode == MODE_EXT40);
          done_q    <= 1'b1;
          src_q     <= (req_mode == MODE_EXT40) ? SRC_EXT40 : SRC_EXT48;
        end
        default: begin
          try_q     <= 1'b1;
          pll_pwr_q <= 1'b1;
          ext_en_q  <= 1'b0;
          ext40_q   <= 1'b0;
          done_q    <= 1'b0;
          src_q     <= SRC_NONE;
        end
      endcase
    end else if (unset_i || pend_q) begin
      if (!stop_q && !pend_q) begin
        // running: stop now, deselect on the following edge
        stop_q <= 1'b1;
        pend_q <= 1'b1;
      end else begin
        pend_q    <= 1'b0;
        try_q     <= 1'b0;
        pll_pwr_q <= 1'b0;
        ext_en_q  <= 1'b0;
        ext40_q   <= 1'b0;
        done_q    <= 1'b0;
        fail_q    <= 1'b0;
        src_q     <= SRC_NONE;
      end
    end else if (try_q && pass_w) begin
      try_q  <= 1'b0;
      done_q <= 1'b1;
      src_q  <= SRC_PLL;
    end else if (try_q && expire_w) begin
      try_q     <= 1'b0;
      pll_pwr_q <= 1'b0;
      if (mode_q == MODE_AUTO) begin
        ext_en_q <= 1'b1;
        ext40_q  <= 1'b1;
        done_q   <= 1'b1;
        src_q    <= SRC_EXT40;
      end else begin
        fail_q <= 1'b1;
      end
    end else if (stop_i) begin
      stop_q <= 1'b1;
    end else if (start_i && done_q && !try_q) begin
      stop_q <= 1'b0;
    end
  end

  assign pll_pwr_o  = pll_pwr_q;
  assign ext_en_o   = ext_en_q;
  assign ext40_o    = ext40_q;
  assign clk_stop_o = stop_q;
  assign busy_o     = try_q;
  assign done_o     = done_q;
  assign fail_o     = fail_q;
  assign src_o      = src_q;

  p_direct_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_req_i && mode_i[1]) |=> (done_o && ext_en_o && !busy_o && clk_stop_o));
  p_trial_stopped_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (clk_stop_o && pll_pwr_o && !ext_en_o && !done_o));
  p_fail_safe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (clk_stop_o && !ext_en_o && !pll_pwr_o && !done_o));
  p_start_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_stop_o) |-> ($past(start_i) && $past(done_o) && !$past(busy_o)));
  p_stop_first_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ext_en_o) && !$past(sel_req_i)) |-> $past(clk_stop_o));
  p_req_stops_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_req_i |=> clk_stop_o);
endmodule

// File: tb/clk_src_qual_test.sv
`timescale 1ns/1ps
module clk_src_qual_test;
  localparam int ST  = 3;
  localparam int SET = 4;
  localparam int WIN = 12;
  localparam int H   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic sel_req = 1'b0, start = 1'b0, stop = 1'b0, unset = 1'b0;
  logic lock = 1'b0, tick = 1'b0;
  logic pll_pwr, ext_en, ext40, clk_stop, busy, done, fail;
  logic [1:0] src;

  int total = 0;
  int bad = 0;
  int cyc_all = 0;
  int dur;

  always #2.5 clk = ~clk;

  clk_src_qual #(.SLOT_TICKS(ST), .SETTLE_SLOTS(SET), .WINDOW_SLOTS(WIN), .HITS_NEEDED(H)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .sel_req_i(sel_req), .start_i(start),
    .stop_i(stop), .unset_i(unset), .pll_lock_i(lock), .tick_i(tick),
    .pll_pwr_o(pll_pwr), .ext_en_o(ext_en), .ext40_o(ext40), .clk_stop_o(clk_stop),
    .busy_o(busy), .done_o(done), .fail_o(fail), .src_o(src)
  );

  // {pll_pwr, ext_en, ext40, clk_stop, busy, done, fail, src}
  function automatic logic [8:0] outs();
    return {pll_pwr, ext_en, ext40, clk_stop, busy, done, fail, src};
  endfunction

  function automatic logic [8:0] exp_vec(input int kind, input logic stopped);
    case (kind)
      0: return {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0};       // none
      1: return {1'b1, 1'b0, 1'b0, stopped, 1'b0, 1'b1, 1'b0, 2'd1};    // pll
      2: return {1'b0, 1'b1, 1'b0, stopped, 1'b0, 1'b1, 1'b0, 2'd2};    // ext48
      3: return {1'b0, 1'b1, 1'b1, stopped, 1'b0, 1'b1, 1'b0, 2'd3};    // ext40
      default: return {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0}; // failed
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic sr, input logic [1:0] md, input logic st,
                      input logic sp, input logic un);
    sel_req = sr; mode = md; start = st; stop = sp; unset = un;
    @(negedge clk);
    sel_req = 1'b0; start = 1'b0; stop = 1'b0; unset = 1'b0;
  endtask

  // runs a PLL trial against a bench model of slots and hits
  task automatic trial(input logic [1:0] m, input int tick_pct, input int lock_pct,
                       input int min_slot, input int max_cyc, input string tag,
                       output int cycles);
    int tcnt = 0, slot = 0, hits = 0, res = 0, miss = 0;
    logic t, l;
    cycles = 0;
    step(1'b1, m, 1'b0, 1'b0, 1'b0);
    while (res == 0 && cycles < max_cyc) begin
      if (!(busy && clk_stop && pll_pwr && !ext_en && !done && !fail)) miss++;
      t = (($urandom % 100) < tick_pct);
      l = (slot + 1 >= min_slot) && (($urandom % 100) < lock_pct);
      tick = t; lock = l;
      if (t) begin
        tcnt++;
        if (tcnt == ST) begin
          tcnt = 0;
          slot++;
          if (slot >= SET && l) hits++;
          if (hits == H) res = 1;
          else if (slot == WIN) res = 2;
        end
      end
      cycles++;
      @(negedge clk);
    end
    tick = 1'b0; lock = 1'b0;
    chk({tag, " R3 trial state"}, miss, 0);
    if (res == 1)       chk({tag, " R4 pass"}, outs(), exp_vec(1, 1'b1));
    else if (res == 2 && m == 2'd0) chk({tag, " R6 fallback"}, outs(), exp_vec(3, 1'b1));
    else if (res == 2)  chk({tag, " R5 fail"}, outs(), exp_vec(4, 1'b1));
  endtask

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 150000) begin
      bad++;
      total++;
      $display("FAIL R1 watchdog actual=%0d expected<150000", cyc_all);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 in reset", outs(), exp_vec(0, 1'b1));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", outs(), exp_vec(0, 1'b1));

    // start ignored without a selection
    step(1'b0, 2'd0, 1'b1, 1'b0, 1'b0);
    chk("R8 start without source", outs(), exp_vec(0, 1'b1));

    step(1'b1, 2'd2, 1'b0, 1'b0, 1'b0);
    chk("R2 ext48 one cycle", outs(), exp_vec(2, 1'b1));
    step(1'b0, 2'd0, 1'b1, 1'b0, 1'b0);
    chk("R8 start releases", outs(), exp_vec(2, 1'b0));
    step(1'b0, 2'd0, 1'b1, 1'b1, 1'b0);
    chk("R9 stop beats start", outs(), exp_vec(2, 1'b1));
    step(1'b0, 2'd0, 1'b1, 1'b0, 1'b0);
    chk("R8 restart", outs(), exp_vec(2, 1'b0));
    step(1'b0, 2'd0, 1'b0, 1'b0, 1'b1);
    chk("R10 unset stops first", outs(), exp_vec(2, 1'b1));
    @(negedge clk);
    chk("R10 unset deselects next", outs(), exp_vec(0, 1'b1));

    step(1'b1, 2'd3, 1'b0, 1'b0, 1'b0);
    chk("R2 ext40 one cycle", outs(), exp_vec(3, 1'b1));
    step(1'b0, 2'd0, 1'b0, 1'b0, 1'b1);
    chk("R10 unset when stopped", outs(), exp_vec(0, 1'b1));

    step(1'b1, 2'd2, 1'b0, 1'b0, 1'b0);
    step(1'b1, 2'd3, 1'b1, 1'b0, 1'b0);
    chk("R11 request beats start", outs(), exp_vec(3, 1'b1));
    step(1'b1, 2'd2, 1'b0, 1'b0, 1'b1);
    chk("R11 request beats unset", outs(), exp_vec(2, 1'b1));

    // steady lock: third hit at slot SET+2, not earlier
    trial(2'd1, 100, 100, 0, 1000, "steady", dur);
    chk("R3 R4 early end cycles", dur, (SET + 2) * ST);
    step(1'b0, 2'd0, 1'b1, 1'b0, 1'b0);
    chk("R8 start after pll", outs(), exp_vec(1, 1'b0));

    trial(2'd1, 100, 0, 0, 1000, "pll miss", dur);
    chk("R5 window length", dur, WIN * ST);
    step(1'b0, 2'd0, 1'b1, 1'b0, 1'b0);
    chk("R8 start ignored on fail", outs(), exp_vec(4, 1'b1));

    trial(2'd0, 100, 0, 0, 1000, "auto miss", dur);
    chk("R6 window length", dur, WIN * ST);

    trial(2'd1, 100, 100, WIN - 2, 1000, "last slot", dur);
    chk("R7 last slot success", dur, WIN * ST);
    trial(2'd1, 100, 100, WIN - 1, 1000, "one short", dur);
    chk("R7 one short fails", fail, 1'b1);

    // abort with two hits in, then a fresh request must start from zero
    trial(2'd1, 100, 100, 0, (SET + 1) * ST, "abort", dur);
    trial(2'd1, 100, 100, 0, 1000, "restart", dur);
    chk("R11 counters restart", dur, (SET + 2) * ST);

    trial(2'd1, 100, 100, 0, 7, "start in trial", dur);
    step(1'b0, 2'd0, 1'b1, 1'b0, 1'b0);
    chk("R8 start ignored while busy", {busy, clk_stop}, 2'b11);

    for (int i = 0; i < 40; i++) begin
      trial(2'($urandom % 2), 60 + int'($urandom % 41), int'($urandom % 60), 0, 5000,
            "random", dur);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule